// File: doc/BRIEF.md
# Set/Clear GPIO Port Controller

This block is a memory-mapped general-purpose I/O port with 32 pins. Software never rewrites a whole data word to change one pin. Instead, it writes a mask to one of four write-only addresses. Each address either raises output levels, lowers output levels, switches pin drivers on, or releases pins to high impedance, and each bit written as 1 picks one pin. Bits written as 0 leave their pins alone. Two agents that own different pins can therefore share the port without a read-modify-write race.

Each pin has an output latch bit, a driver-enable bit and an input sample. The pad level is resolved outside the block and fed back on `pin_in`. It passes through a synchronizer chain before a read of the pin-level address returns it. The register bus is a plain strobe interface. A write takes effect at the clock edge that samples it. Read data appears on the cycle after the read strobe and holds until the next read.

Top module: `gpio_setclr_port`

## Requirements
- R1: While reset is low and right after it, every output latch bit is 0, every driver enable is 0 and the read data is 0, so every pin floats.
- R2: A write to address 0x00 sets the output latch bit of each pin whose write-data bit is 1 and leaves all other latch bits unchanged.
- R3: A write to address 0x10 clears the output latch bit of each pin whose write-data bit is 1 and leaves all other latch bits unchanged.
- R4: A write to address 0x20 sets the driver enable of each pin whose write-data bit is 1 and leaves all other enables unchanged.
- R5: A write to address 0x30 clears the driver enable of each pin whose write-data bit is 1, returning that pin to high impedance, and leaves all other enables unchanged.
- R6: A read of address 0x40 returns the pin levels, with bit n holding pin n. The value reaches the read data in the cycle after the read strobe. A change on `pin_in` is first visible to a read strobe sampled two edges after the edge where the change is present. The read data holds while no read is strobed.
- R7: A read of any address other than 0x40, including the four write-only addresses, returns 0.
- R8: A write to address 0x40 or to any unmapped address changes neither the output latches nor the driver enables.
- R9: Writes to the latch addresses never change the driver enables, and writes to the enable addresses never change the latches. A floating pin therefore keeps its latch value and drives it again once it is enabled.
- R10: A write strobe and a read strobe in the same cycle are both served. The write takes its normal effect, and the read returns what a read alone would return at that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data, one bit per pin |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| pin_out | output | 32 | Output latch value per pin |
| pin_oe | output | 32 | Driver enable per pin |
| pin_in | input | 32 | Resolved pad level per pin |

## Verification
A write and a read can land in the same cycle because the read and write strobes are independent and share one address. The bench raises both strobes together at a set address and at the pin-level address. For the set address it judges the latch change and a zero read. For the pin-level address it judges unchanged latches and the current pin sample. Pin sampling also keeps running under bus writes. The bench holds the read strobe on while an external pin level changes, and checks the exact cycle at which the new level appears.

// File: rtl/gpio_sc_pkg.sv
package gpio_sc_pkg;

    // Decoded access kind for one bus address
    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_SET,
        ACC_CLR,
        ACC_DRV,
        ACC_FLT,
        ACC_PINS
    } acc_e;

    // Address map; software relies on these offsets
    localparam logic [7:0] OFS_SET  = 8'h00;
    localparam logic [7:0] OFS_CLR  = 8'h10;
    localparam logic [7:0] OFS_DRV  = 8'h20;
    localparam logic [7:0] OFS_FLT  = 8'h30;
    localparam logic [7:0] OFS_PINS = 8'h40;

endpackage

// File: rtl/gpio_sc_decode.sv
module gpio_sc_decode
    import gpio_sc_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output acc_e              kind
);
    always_comb begin
        if      (addr == ADDR_W'(OFS_SET))  kind = ACC_SET;
        else if (addr == ADDR_W'(OFS_CLR))  kind = ACC_CLR;
        else if (addr == ADDR_W'(OFS_DRV))  kind = ACC_DRV;
        else if (addr == ADDR_W'(OFS_FLT))  kind = ACC_FLT;
        else if (addr == ADDR_W'(OFS_PINS)) kind = ACC_PINS;
        else                                kind = ACC_NONE;
    end
endmodule

// File: rtl/gpio_sc_bitreg.sv
// Bank of independent bits, each raised or lowered by a mask strobe.
module gpio_sc_bitreg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_en,
    input  logic         clr_en,
    input  logic [W-1:0] mask,
    output logic [W-1:0] q
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q[b] <= 1'b0;
            else if (set_en && mask[b])
                q[b] <= 1'b1;
            else if (clr_en && mask[b])
                q[b] <= 1'b0;
        end
    end
endmodule

// File: rtl/gpio_sc_sync.sv
// Multi-stage input synchronizer, one chain per pin.
module gpio_sc_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                chain[s] <= '0;
            else if (s == 0)
                chain[s] <= d;
            else
                chain[s] <= chain[(s == 0) ? 0 : s-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_setclr_port.sv
module gpio_setclr_port
    import gpio_sc_pkg::*;
#(
    parameter int NUM_PINS    = 32,
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [NUM_PINS-1:0] bus_wdata,
    input  logic                bus_rd,
    output logic [NUM_PINS-1:0] bus_rdata,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    input  logic [NUM_PINS-1:0] pin_in
);
    acc_e                kind;
    logic [NUM_PINS-1:0] pins_sync;

    gpio_sc_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr (bus_addr),
        .kind (kind)
    );

    // Output latches: set and clear masks
    gpio_sc_bitreg #(.W(NUM_PINS)) u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_en (bus_wr && (kind == ACC_SET)),
        .clr_en (bus_wr && (kind == ACC_CLR)),
        .mask   (bus_wdata),
        .q      (pin_out)
    );

    // Driver enables: drive and float masks
    gpio_sc_bitreg #(.W(NUM_PINS)) u_enable (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_en (bus_wr && (kind == ACC_DRV)),
        .clr_en (bus_wr && (kind == ACC_FLT)),
        .mask   (bus_wdata),
        .q      (pin_oe)
    );

    gpio_sc_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (pins_sync)
    );

    // Read data: loaded on each read strobe, held otherwise
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (bus_rd)
            bus_rdata <= (kind == ACC_PINS) ? pins_sync : '0;
    end
endmodule

// File: rtl/gpio_sc_checker.sv
module gpio_sc_checker #(
    parameter int N      = 32,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [N-1:0]      bus_wdata,
    input logic              bus_rd,
    input logic [N-1:0]      bus_rdata,
    input logic [N-1:0]      pin_out,
    input logic [N-1:0]      pin_oe
);
    logic wr_set, wr_clr, wr_drv, wr_flt;
    assign wr_set = bus_wr && (bus_addr == ADDR_W'(8'h00));
    assign wr_clr = bus_wr && (bus_addr == ADDR_W'(8'h10));
    assign wr_drv = bus_wr && (bus_addr == ADDR_W'(8'h20));
    assign wr_flt = bus_wr && (bus_addr == ADDR_W'(8'h30));

    a_r2_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> (((pin_out & $past(bus_wdata)) == $past(bus_wdata)) &&
                    ((pin_out & ~$past(bus_wdata)) == ($past(pin_out) & ~$past(bus_wdata)))));

    a_r3_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> (((pin_out & $past(bus_wdata)) == '0) &&
                    ((pin_out & ~$past(bus_wdata)) == ($past(pin_out) & ~$past(bus_wdata)))));

    a_r4_drive_bits: assert property (@(posedge clk) disable iff (!rst_n)
        wr_drv |=> (((pin_oe & $past(bus_wdata)) == $past(bus_wdata)) &&
                    ((pin_oe & ~$past(bus_wdata)) == ($past(pin_oe) & ~$past(bus_wdata)))));

    a_r5_float_bits: assert property (@(posedge clk) disable iff (!rst_n)
        wr_flt |=> (((pin_oe & $past(bus_wdata)) == '0) &&
                    ((pin_oe & ~$past(bus_wdata)) == ($past(pin_oe) & ~$past(bus_wdata)))));

    // R8 and R9: latches move only on latch writes
    a_r9_latch_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_set || wr_clr) |=> $stable(pin_out));

    // R8 and R9: enables move only on enable writes
    a_r9_enable_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_drv || wr_flt) |=> $stable(pin_oe));

    // R7 and R10: non-pin reads return zero even alongside a write
    a_r7_zero_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (bus_addr != ADDR_W'(8'h40))) |=> (bus_rdata == '0));

    a_r6_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
endmodule

bind gpio_setclr_port gpio_sc_checker #(.N(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
);

// File: tb/gpio_setclr_port_tb.sv
module gpio_setclr_port_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  bus_addr;
    logic        bus_wr;
    logic [31:0] bus_wdata;
    logic        bus_rd;
    logic [31:0] bus_rdata;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;
    logic [31:0] pin_in;
    logic [31:0] ext_val;   // level an external device holds on a floating pin

    int checks = 0;
    int fails  = 0;
    logic [31:0] exp_out = '0;
    logic [31:0] exp_oe  = '0;
    logic [31:0] rd_val;
    logic [31:0] prng = 32'h1234_5678;

    always #10 clk = ~clk;   // 50 MHz

    // Tri-state pad model: driven pin shows its latch, floating pin shows the external level
    for (genvar p = 0; p < 32; p++) begin : g_pad
        assign pin_in[p] = pin_oe[p] ? pin_out[p] : ext_val[p];
    end

    gpio_setclr_port u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .pin_out(pin_out), .pin_oe(pin_oe), .pin_in(pin_in)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        case (a)
            8'h00: exp_out = exp_out | d;
            8'h10: exp_out = exp_out & ~d;
            8'h20: exp_oe  = exp_oe | d;
            8'h30: exp_oe  = exp_oe & ~d;
            default: ;
        endcase
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    function automatic logic [31:0] pad_exp();
        return (exp_oe & exp_out) | (~exp_oe & ext_val);
    endfunction

    task automatic read_pins_chk(input string req);
        repeat (3) @(negedge clk);
        rd_reg(8'h40, rd_val);
        chk(req, "pin levels", rd_val, pad_exp());
    endtask

    task automatic chk_state(input string req);
        chk(req, "latches", pin_out, exp_out);
        chk(req, "enables", pin_oe, exp_oe);
    endtask

    function automatic logic [31:0] step(input logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        return y ^ (y << 5);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0; bus_rd = 1'b0;
        ext_val = 32'hA5A5_0F0F;
        repeat (3) @(negedge clk);
        chk("R1", "latches in reset", pin_out, '0);
        chk("R1", "enables in reset", pin_oe, '0);
        chk("R1", "rdata in reset", bus_rdata, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_state("R1");
        read_pins_chk("R1");

        // Per-pin sweep
        for (int i = 0; i < 32; i++) begin
            ext_val = ~(32'h1 << i) ^ (32'h0101_0101 << (i % 8));
            wr_reg(8'h00, 32'h1 << i);
            chk("R2", "set one pin", pin_out, exp_out);
            wr_reg(8'h20, 32'h1 << i);
            chk("R4", "drive one pin", pin_oe, exp_oe);
            read_pins_chk("R6");
            wr_reg(8'h10, 32'h1 << i);
            chk("R3", "clear one pin", pin_out, exp_out);
            wr_reg(8'h30, 32'h1 << i);
            chk("R5", "float one pin", pin_oe, exp_oe);
        end

        // Mixed masks against the arithmetic model
        for (int k = 0; k < 48; k++) begin
            prng = step(prng);
            ext_val = step(prng ^ 32'h5A5A_5A5A);
            wr_reg({2'b00, prng[1:0], 4'h0}, step(prng));
            chk_state("R9");
            if (k % 4 == 0) read_pins_chk("R6");
        end

        // Floating pin keeps its latch and drives it again once enabled (R9)
        wr_reg(8'h30, 32'hFFFF_FFFF);
        wr_reg(8'h00, 32'h0000_8001);
        wr_reg(8'h10, 32'h0000_0010);
        ext_val = 32'h0000_0010;
        read_pins_chk("R9");
        wr_reg(8'h20, 32'h0000_8011);
        read_pins_chk("R9");

        // Write-only and unmapped reads return zero (R7)
        wr_reg(8'h00, 32'hFFFF_0000);
        wr_reg(8'h20, 32'h00FF_00FF);
        for (int j = 0; j < 7; j++) begin
            logic [7:0] a;
            a = (j < 4) ? 8'(j * 16) : ((j == 4) ? 8'h04 : ((j == 5) ? 8'h50 : 8'hFF));
            rd_reg(a, rd_val);
            chk("R7", "non-pin read", rd_val, '0);
        end

        // Writes to the pin address and unmapped addresses ignored (R8)
        for (int j = 0; j < 4; j++) begin
            logic [7:0] a;
            a = (j == 0) ? 8'h40 : ((j == 1) ? 8'h08 : ((j == 2) ? 8'h44 : 8'hFC));
            wr_reg(a, 32'hFFFF_FFFF);
            chk_state("R8");
            wr_reg(a, 32'h0000_0000);
            chk_state("R8");
        end

        // Synchronizer latency with the read strobe held on (R6)
        wr_reg(8'h30, 32'hFFFF_FFFF);
        ext_val = 32'h1111_1111;
        repeat (4) @(negedge clk);
        bus_addr = 8'h40; bus_rd = 1'b1;
        ext_val = 32'hEEEE_EEEE;              // present at edge E0
        @(negedge clk);
        chk("R6", "read at change edge", bus_rdata, 32'h1111_1111);
        @(negedge clk);
        chk("R6", "read one edge later", bus_rdata, 32'h1111_1111);
        @(negedge clk);
        chk("R6", "read two edges later", bus_rdata, 32'hEEEE_EEEE);
        bus_rd = 1'b0;
        ext_val = 32'h2222_2222;
        repeat (4) @(negedge clk);
        chk("R6", "rdata held without read", bus_rdata, 32'hEEEE_EEEE);

        // Read and write in one cycle (R10)
        @(negedge clk);
        bus_addr = 8'h00; bus_wdata = 32'h0F00_0000; bus_wr = 1'b1; bus_rd = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        exp_out = exp_out | 32'h0F00_0000;
        chk("R10", "latch after joint access", pin_out, exp_out);
        chk("R10", "rdata after joint access", bus_rdata, '0);
        @(negedge clk);
        bus_addr = 8'h40; bus_wdata = 32'hFFFF_FFFF; bus_wr = 1'b1; bus_rd = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        chk("R10", "pins read with write", bus_rdata, pad_exp());
        chk_state("R10");

        // Reset returns everything to floating (R1)
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        exp_out = '0; exp_oe = '0;
        chk("R1", "rdata after re-reset", bus_rdata, '0);
        rst_n = 1'b1;
        chk_state("R1");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule